// File: doc/BRIEF.md
# Parallel 64-Point Radix-4 Fast Fourier Transform

This block turns a whole frame of 64 complex time-domain samples, presented at once on two wide buses (real and imaginary), into 64 complex frequency bins. The work is split over three cascaded radix-4 stages. Each stage has sixteen four-input butterflies. Every butterfly first rotates three of its inputs by constant twiddle factors and then takes a four-point DFT of the result. The wiring between stages is a fixed permutation that depends only on the stage number. It is arranged so that the last stage delivers the bins in natural order, with no separate reordering step.

Each stage ends in a register bank, so a frame that enters with the input strobe comes out three clock cycles later with the output strobe. A new frame can be accepted on every cycle. Each butterfly divides its result by four, with rounding and saturation, so the full transform is scaled by 1/64 and keeps the input word width. All twiddle constants are computed when the design is elaborated, from the butterfly's position and the stage span.

Top module: `fft64_r4`

## Requirements
- R1: A cycle with `rst` high clears `out_valid` at that clock edge, so `out_valid` reads 0 in the following cycle. A frame that is still in flight when reset is applied never produces an output strobe.
- R2: `out_valid` is high in exactly those cycles that come three clock cycles after a cycle in which `in_valid` was high. There is one output strobe per input strobe.
- R3: Samples and bins are packed with index n at bits [16n+15:16n] of the real and imaginary buses, in 16-bit two's complement. When no saturation occurs, output bin k equals (1/64)·Σ x[n]·e^(−i2πkn/64) to within ±3 LSB in each of the real and imaginary parts.
- R4: A frame in which every sample holds the same complex value yields exactly that value in bin 0 and exactly zero in every other bin.
- R5: A frame with a real value A (a multiple of 64) at sample 0 and zeros everywhere else yields exactly A/64 in the real part of every bin and exactly zero in every imaginary part.
- R6: A complex exponential of amplitude A and frequency index k0 yields approximately A in the real part of bin k0, and approximately zero in all other bins and in every imaginary part.
- R7: While `out_valid` is low, both output buses keep their last value. Input data that is not marked by `in_valid` has no effect on them.
- R8: Frames presented on consecutive cycles come out on consecutive cycles, in the same order, and each is transformed independently of its neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the strobe pipeline |
| in_valid | input | 1 | Marks the cycle in which the input buses carry a frame |
| in_re | input | 1024 | Real parts of the 64 input samples, sample n at [16n+15:16n] |
| in_im | input | 1024 | Imaginary parts of the 64 input samples |
| out_valid | output | 1 | Marks the cycle in which the output buses carry a new spectrum |
| out_re | output | 1024 | Real parts of the 64 bins, bin k at [16k+15:16k] |
| out_im | output | 1024 | Imaginary parts of the 64 bins |

## Verification
The datapath has no feedback, so a bad gather or scatter index, or a wrong twiddle, shows up as a wrong bin in the very frame that passes through it, three cycles after that frame's strobe. The constant-frame and impulse frames give exact answers and expose sign and routing slips with no tolerance. The tone and pseudo-random frames, compared against a DFT evaluated in real arithmetic, catch twiddle errors that cancel on those symmetric frames. A broken strobe pipeline shows up at once as a missing, early or doubled `out_valid`, or as bins that change while `out_valid` is low.

// File: rtl/fft64_pkg.sv
package fft64_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Round a real value scaled by 2^frac to the nearest integer.
  function automatic int quant_frac(input real v, input int frac);
    real s;
    s = v * (2.0 ** frac);
    return (s >= 0.0) ? $rtoi(s + 0.5) : $rtoi(s - 0.5);
  endfunction

  // Real part of exp(-i*2*pi*e/span), fixed point.
  function automatic int twid_re(input int e, input int span, input int frac);
    return quant_frac($cos(TWO_PI * e / span), frac);
  endfunction

  // Imaginary part of exp(-i*2*pi*e/span), fixed point.
  function automatic int twid_im(input int e, input int span, input int frac);
    return quant_frac(-$sin(TWO_PI * e / span), frac);
  endfunction

  // Index of the m-th operand that butterfly (j,k) reads from the stage input.
  function automatic int gather_idx(input int j, input int k, input int m, input int stride);
    return j * 4 * stride + k + m * stride;
  endfunction

  // Index that receives the m-th result of butterfly (j,k) in the stage output.
  function automatic int scatter_idx(input int j, input int k, input int m, input int stride,
                                     input int quarter);
    return (j + m * quarter) * stride + k;
  endfunction

endpackage

// File: rtl/r4_bfly.sv
module r4_bfly #(
  parameter int D_W  = 16,
  parameter int TW_W = 16,
  parameter int J    = 0,
  parameter int SPAN = 4
) (
  input  logic [3:0][D_W-1:0] a_re,
  input  logic [3:0][D_W-1:0] a_im,
  output logic [3:0][D_W-1:0] y_re,
  output logic [3:0][D_W-1:0] y_im
);

  localparam int FRAC  = TW_W - 2;        // twiddle 1.0 == 2^FRAC
  localparam int MW    = D_W + TW_W;      // product width
  localparam int PW    = MW + 1;          // rotated operand width
  localparam int SW    = PW + 2;          // four-term sum width
  localparam int SHIFT = FRAC + 2;        // remove twiddle scale and divide by 4

  localparam logic signed [SW-1:0] RND = SW'(2 ** (SHIFT - 1));
  localparam logic signed [SW-1:0] HI  = SW'(2 ** (D_W - 1) - 1);
  localparam logic signed [SW-1:0] LO  = -HI - SW'(1);

  logic [3:0][PW-1:0] b_re, b_im;

  // Operand 0 always has twiddle 1: align it to the rotated operands.
  assign b_re[0] = {{(PW - D_W - FRAC){a_re[0][D_W-1]}}, a_re[0], {FRAC{1'b0}}};
  assign b_im[0] = {{(PW - D_W - FRAC){a_im[0][D_W-1]}}, a_im[0], {FRAC{1'b0}}};

  for (genvar m = 1; m < 4; m++) begin : g_rot
    localparam logic signed [TW_W-1:0] WR = TW_W'(fft64_pkg::twid_re(J * m, SPAN, FRAC));
    localparam logic signed [TW_W-1:0] WI = TW_W'(fft64_pkg::twid_im(J * m, SPAN, FRAC));
    logic signed [MW-1:0] p_rr, p_ii, p_ri, p_ir;
    assign p_rr = $signed(a_re[m]) * WR;
    assign p_ii = $signed(a_im[m]) * WI;
    assign p_ri = $signed(a_re[m]) * WI;
    assign p_ir = $signed(a_im[m]) * WR;
    assign b_re[m] = PW'(p_rr) - PW'(p_ii);
    assign b_im[m] = PW'(p_ri) + PW'(p_ir);
  end

  function automatic logic [D_W-1:0] rnd_sat(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] t;
    t = (v + RND) >>> SHIFT;
    if (t > HI)      return HI[D_W-1:0];
    else if (t < LO) return LO[D_W-1:0];
    else             return t[D_W-1:0];
  endfunction

  logic signed [SW-1:0] xr [4];
  logic signed [SW-1:0] xi [4];

  // Four-point DFT with kernel -i, result m scaled by 1/4.
  always_comb begin
    for (int n = 0; n < 4; n++) begin
      xr[n] = SW'($signed(b_re[n]));
      xi[n] = SW'($signed(b_im[n]));
    end
    y_re[0] = rnd_sat(xr[0] + xr[1] + xr[2] + xr[3]);
    y_im[0] = rnd_sat(xi[0] + xi[1] + xi[2] + xi[3]);
    y_re[1] = rnd_sat(xr[0] + xi[1] - xr[2] - xi[3]);
    y_im[1] = rnd_sat(xi[0] - xr[1] - xi[2] + xr[3]);
    y_re[2] = rnd_sat(xr[0] - xr[1] + xr[2] - xr[3]);
    y_im[2] = rnd_sat(xi[0] - xi[1] + xi[2] - xi[3]);
    y_re[3] = rnd_sat(xr[0] - xi[1] - xr[2] + xi[3]);
    y_im[3] = rnd_sat(xi[0] + xr[1] - xi[2] - xr[3]);
  end

endmodule

// File: rtl/r4_stage.sv
module r4_stage #(
  parameter int N_STG = 3,
  parameter int STG   = 1,
  parameter int D_W   = 16,
  parameter int TW_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [4**N_STG*D_W-1:0] in_re,
  input  logic [4**N_STG*D_W-1:0] in_im,
  output logic               out_vld,
  output logic [4**N_STG*D_W-1:0] out_re,
  output logic [4**N_STG*D_W-1:0] out_im
);

  localparam int N  = 4 ** N_STG;   // points per frame
  localparam int L  = 4 ** STG;     // span of this stage
  localparam int R  = N / L;        // operand stride
  localparam int LX = L / 4;        // distinct twiddle sets

  logic [N*D_W-1:0] nxt_re, nxt_im;

  for (genvar j = 0; j < LX; j++) begin : g_tw
    for (genvar k = 0; k < R; k++) begin : g_pos
      logic [3:0][D_W-1:0] g_re, g_im, s_re, s_im;

      for (genvar m = 0; m < 4; m++) begin : g_leg
        localparam int SRC = fft64_pkg::gather_idx(j, k, m, R);
        localparam int DST = fft64_pkg::scatter_idx(j, k, m, R, LX);
        assign g_re[m] = in_re[SRC*D_W +: D_W];
        assign g_im[m] = in_im[SRC*D_W +: D_W];
        assign nxt_re[DST*D_W +: D_W] = s_re[m];
        assign nxt_im[DST*D_W +: D_W] = s_im[m];
      end

      r4_bfly #(
        .D_W (D_W),
        .TW_W(TW_W),
        .J   (j),
        .SPAN(L)
      ) u_bfly (
        .a_re(g_re),
        .a_im(g_im),
        .y_re(s_re),
        .y_im(s_im)
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_re <= nxt_re;
      out_im <= nxt_im;
    end
  end

endmodule

// File: rtl/fft64_r4.sv
module fft64_r4 #(
  parameter int N_STG = 3,
  parameter int D_W   = 16,
  parameter int TW_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [4**N_STG*D_W-1:0] in_re,
  input  logic [4**N_STG*D_W-1:0] in_im,
  output logic                    out_valid,
  output logic [4**N_STG*D_W-1:0] out_re,
  output logic [4**N_STG*D_W-1:0] out_im
);

  localparam int N  = 4 ** N_STG;
  localparam int BW = N * D_W;

  logic [N_STG:0][BW-1:0] lnk_re, lnk_im;
  logic [N_STG:0]         lnk_v;

  assign lnk_re[0] = in_re;
  assign lnk_im[0] = in_im;
  assign lnk_v[0]  = in_valid;

  for (genvar s = 0; s < N_STG; s++) begin : g_stage
    r4_stage #(
      .N_STG(N_STG),
      .STG  (s + 1),
      .D_W  (D_W),
      .TW_W (TW_W)
    ) u_stage (
      .clk    (clk),
      .rst    (rst),
      .in_vld (lnk_v[s]),
      .in_re  (lnk_re[s]),
      .in_im  (lnk_im[s]),
      .out_vld(lnk_v[s+1]),
      .out_re (lnk_re[s+1]),
      .out_im (lnk_im[s+1])
    );
  end

  assign out_valid = lnk_v[N_STG];
  assign out_re    = lnk_re[N_STG];
  assign out_im    = lnk_im[N_STG];

endmodule

// File: rtl/fft64_r4_chk.sv
module fft64_r4_chk #(
  parameter int N_STG = 3,
  parameter int D_W   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic [4**N_STG*D_W-1:0] out_re,
  input logic [4**N_STG*D_W-1:0] out_im
);

  logic [N_STG-1:0] strobe_hist;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_hist <= '0;
      armed       <= 1'b0;
    end else begin
      strobe_hist <= N_STG'({strobe_hist, in_valid});
      armed       <= 1'b1;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == strobe_hist[N_STG-1]));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !out_valid) |-> ($stable(out_re) && $stable(out_im)));

  // R3
  known_bins_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!$isunknown(out_re) && !$isunknown(out_im)));

endmodule

bind fft64_r4 fft64_r4_chk #(
  .N_STG(N_STG),
  .D_W  (D_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_re   (out_re),
  .out_im   (out_im)
);

// File: tb/fft64_r4_test.sv
module fft64_r4_test;

  localparam int  CLK_PER = 10;
  localparam int  NP      = 64;
  localparam int  DW      = 16;
  localparam real TOL     = 3.0;
  localparam real TWO_PI  = 6.283185307179586;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [NP*DW-1:0] in_re = '0;
  logic [NP*DW-1:0] in_im = '0;
  logic             out_valid;
  logic [NP*DW-1:0] out_re, out_im;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  int xr [NP];
  int xi [NP];
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PER/2) clk = ~clk;

  fft64_r4 uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  function automatic int bin_re(input int k);
    return int'($signed(out_re[k*DW +: DW]));
  endfunction

  function automatic int bin_im(input int k);
    return int'($signed(out_im[k*DW +: DW]));
  endfunction

  function automatic int next_rand(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % (2 * span + 1)) - span;
  endfunction

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pack_inputs();
    for (int n = 0; n < NP; n++) begin
      in_re[n*DW +: DW] = DW'(xr[n]);
      in_im[n*DW +: DW] = DW'(xi[n]);
    end
  endtask

  // Present the frame held in xr/xi and wait until the cycle of its output strobe.
  task automatic run_frame();
    @(negedge clk);
    pack_inputs();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Compare every bin against a DFT of xr/xi evaluated in real arithmetic.
  task automatic chk_dft(input string req);
    for (int k = 0; k < NP; k++) begin
      real er, ei, th, dr, di;
      er = 0.0; ei = 0.0;
      for (int n = 0; n < NP; n++) begin
        th = TWO_PI * ((k * n) % NP) / NP;
        er += xr[n] * $cos(th) + xi[n] * $sin(th);
        ei += xi[n] * $cos(th) - xr[n] * $sin(th);
      end
      er = er / NP; ei = ei / NP;
      dr = bin_re(k) - er; di = bin_im(k) - ei;
      if (dr < 0.0) dr = -dr;
      if (di < 0.0) di = -di;
      n_checks++;
      if (dr > TOL || di > TOL) begin
        n_fails++;
        $display("FAIL %s bin %0d: actual=(%0d,%0d) expected=(%0.2f,%0.2f)",
                 req, k, bin_re(k), bin_im(k), er, ei);
      end
    end
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_int("R1", "out_valid after reset", int'(out_valid), 0);
    // Frame in flight when reset hits must not appear.
    for (int n = 0; n < NP; n++) begin xr[n] = 77; xi[n] = 0; end
    @(negedge clk);
    pack_inputs();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk_int("R1", "out_valid for flushed frame", int'(out_valid), 0);
    end
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_int("R2", "strobe at +1", int'(out_valid), 0);
    @(negedge clk);
    chk_int("R2", "strobe at +2", int'(out_valid), 0);
    @(negedge clk);
    chk_int("R2", "strobe at +3", int'(out_valid), 1);
    @(negedge clk);
    chk_int("R2", "strobe at +4", int'(out_valid), 0);
  endtask

  task automatic t_constant();
    for (int n = 0; n < NP; n++) begin xr[n] = 1234; xi[n] = -567; end
    run_frame();
    chk_int("R4", "out_valid", int'(out_valid), 1);
    for (int k = 0; k < NP; k++) begin
      chk_int("R4", $sformatf("bin %0d re", k), bin_re(k), (k == 0) ? 1234 : 0);
      chk_int("R4", $sformatf("bin %0d im", k), bin_im(k), (k == 0) ? -567 : 0);
    end
  endtask

  task automatic t_impulse();
    for (int n = 0; n < NP; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 6400;
    run_frame();
    for (int k = 0; k < NP; k++) begin
      chk_int("R5", $sformatf("bin %0d re", k), bin_re(k), 100);
      chk_int("R5", $sformatf("bin %0d im", k), bin_im(k), 0);
    end
  endtask

  task automatic t_tone();
    for (int n = 0; n < NP; n++) begin
      real th;
      th = TWO_PI * ((5 * n) % NP) / NP;
      xr[n] = $rtoi(10000.0 * $cos(th) + ((10000.0 * $cos(th) >= 0.0) ? 0.5 : -0.5));
      xi[n] = $rtoi(10000.0 * $sin(th) + ((10000.0 * $sin(th) >= 0.0) ? 0.5 : -0.5));
    end
    run_frame();
    chk_dft("R6");
    n_checks++;
    if (bin_re(5) < 9997 || bin_re(5) > 10003) begin
      n_fails++;
      $display("FAIL R6 peak bin 5: actual=%0d expected=10000", bin_re(5));
    end
  endtask

  task automatic t_random();
    for (int f = 0; f < 3; f++) begin
      for (int n = 0; n < NP; n++) begin
        xr[n] = next_rand(8000);
        xi[n] = next_rand(8000);
      end
      run_frame();
      chk_dft("R3");
    end
  endtask

  task automatic t_hold();
    logic [NP*DW-1:0] keep_re, keep_im;
    for (int n = 0; n < NP; n++) begin xr[n] = next_rand(3000); xi[n] = next_rand(3000); end
    run_frame();
    keep_re = out_re;
    keep_im = out_im;
    for (int c = 0; c < 6; c++) begin
      for (int n = 0; n < NP; n++) begin xr[n] = next_rand(9000); xi[n] = next_rand(9000); end
      pack_inputs();
      @(negedge clk);
      chk_int("R7", "out_valid idle", int'(out_valid), 0);
      chk_int("R7", "bins held", int'(out_re == keep_re && out_im == keep_im), 1);
    end
  endtask

  task automatic t_stream();
    for (int f = 0; f < 3; f++) begin
      @(negedge clk);
      for (int n = 0; n < NP; n++) begin xr[n] = 300 * (f + 1); xi[n] = -70 * (f + 1); end
      pack_inputs();
      in_valid = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int f = 0; f < 3; f++) begin
      if (f > 0) @(negedge clk);
      chk_int("R8", $sformatf("frame %0d strobe", f), int'(out_valid), 1);
      chk_int("R8", $sformatf("frame %0d bin0 re", f), bin_re(0), 300 * (f + 1));
      chk_int("R8", $sformatf("frame %0d bin0 im", f), bin_im(0), -70 * (f + 1));
      chk_int("R8", $sformatf("frame %0d bin9 re", f), bin_re(9), 0);
    end
    @(negedge clk);
    chk_int("R8", "strobe after burst", int'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_constant();
    t_impulse();
    t_tone();
    t_random();
    t_hold();
    t_stream();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule